// File: doc/BRIEF.md
# Packed-Word I2C Data Queue

This block sits between a host register port and the byte-wide shift engine of a packet-mode I2C controller. It holds two queues of 32-bit words. The host pushes header and payload words into the transmit queue and pops received words from the receive queue. Four payload bytes share each word, with the lowest byte first. On the engine side, the transmit word at the head of the queue is offered one byte at a time. Received bytes are gathered into words before they enter the receive queue.

A control register holds a trigger level for each direction and one flush bit for each queue. A flush bit clears itself once its queue has been emptied. A status register gives the number of free transmit slots and the number of filled receive slots. Two request flags compare those counts against the trigger levels, so an interrupt layer outside this block can decide when to service the queues. A write to a full transmit queue and a read from an empty receive queue are each flagged for one cycle. The bus engine and the interrupt registers are not part of this block.

Host register word addresses: 0 is the transmit data port (write only), 1 is the receive data port (read pops), 2 is control, and 3 is status.

Top module: `i2cWordQueue`

## Requirements
- R1: After reset, control reads 0, status reads free=8 and filled=0, txReq is 1 (8 > 0), rxReq is 0, and txByteValid is 0.
- R2: A transmit word is presented on txByteData low byte first: bits [7:0], then [15:8], then [23:16], then [31:24]. Each txByteTake advances the presentation by one byte.
- R3: If txByteTake is asserted together with txByteLast, the head word is retired after the current byte. Its remaining upper bytes are skipped, and the next word starts at its bits [7:0].
- R4: Received bytes are packed little-endian, with the first byte in bits [7:0]. A word enters the receive queue after its fourth byte, or earlier on a byte flagged rxByteLast. In an early word, the unfilled upper bytes read as zero.
- R5: Status bits [7:4] hold the number of free transmit word slots (0..8). Status bits [3:0] hold the number of receive words available (0..8).
- R6: Control bit 1 flushes the transmit queue and bit 0 flushes the receive queue. A bit written as 1 reads back as 1 in the following cycle. In the cycle after that, the bit reads 0 and its queue is empty, with any partial byte state discarded.
- R7: Control bits [7:5] hold the transmit trigger and bits [4:2] hold the receive trigger, and both read back as written. txReq equals (free > transmit trigger), and rxReq equals (filled > receive trigger).
- R8: A write to the transmit data port while 8 words are queued raises txOverflow in that cycle. The word is dropped and the queue contents are unchanged.
- R9: A read of the receive data port while the queue is empty returns 0 and raises rxUnderflow in that cycle.
- R10: Each queue delivers words in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Host write strobe |
| regRead | input | 1 | Host read strobe (pops the receive queue at address 1) |
| regAddr | input | 2 | Host word address |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Host read data, combinational from regAddr |
| txOverflow | output | 1 | Write to a full transmit queue this cycle |
| rxUnderflow | output | 1 | Read from an empty receive queue this cycle |
| txReq | output | 1 | Transmit free count above trigger |
| rxReq | output | 1 | Receive filled count above trigger |
| txByteValid | output | 1 | A transmit byte is on offer |
| txByteData | output | 8 | Current transmit byte |
| txByteTake | input | 1 | Engine consumes the offered byte |
| txByteLast | input | 1 | With take: this byte ends the payload |
| rxByteValid | input | 1 | Engine delivers a received byte |
| rxByteData | input | 8 | Received byte |
| rxByteLast | input | 1 | Received byte ends the payload |
| rxByteReady | output | 1 | Receive queue has room for a word |

## Verification
The bench goes after byte order and partial words in both directions. A swapped lane would show up as a byte out of place, and a stale byte index after an early retirement would start the next word at the wrong byte. It fills the transmit queue to the brim and writes once more. A design that let the write through would corrupt the oldest word or show a free count that wrapped. It reads the flush bits in the cycle after the write and in the cycle after that. A bit that never cleared, or one that cleared before the queue emptied, fails there. Trigger sweeps catch an off-by-one comparison, and an empty read catches a design that returned stale data.

// File: rtl/i2cWordQueuePkg.sv
package i2cWordQueuePkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] ADDR_TXDATA = 2'd0;
  localparam logic [1:0] ADDR_RXDATA = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } queueStrobes_t;
endpackage

// File: rtl/wordFifo.sv
module wordFifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/queueDatapath.sv
module queueDatapath
  import i2cWordQueuePkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned LANES = WORD_W / BYTE_W,
  localparam int unsigned LW = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  queueStrobes_t     strobe,
  input  logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxHead,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              txByteValid,
  output logic [BYTE_W-1:0] txByteData,
  input  logic              txByteTake,
  input  logic              txByteLast,
  input  logic              rxByteValid,
  input  logic [BYTE_W-1:0] rxByteData,
  input  logic              rxByteLast,
  output logic              rxByteReady
);
  logic [WORD_W-1:0] txHead, rxWord;
  logic txEmpty, rxFull, txPop, rxPush, txStep;
  logic [LW-1:0] txLane, rxLane;
  logic [WORD_W-1:0] rxAccum;

  wordFifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) txQ (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush),
    .push(strobe.txPush), .pushData(txWord),
    .pop(txPop), .headData(txHead),
    .count(txCount), .full(txFull), .empty(txEmpty));

  wordFifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush),
    .push(rxPush), .pushData(rxWord),
    .pop(strobe.rxPop), .headData(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty));

  // transmit serialiser: select lane of the head word
  assign txByteValid = !txEmpty && !strobe.txFlush;
  assign txStep      = txByteTake && txByteValid;
  assign txPop       = txStep && (txByteLast || txLane == LW'(LANES - 1));

  always_comb begin
    txByteData = '0;
    for (int i = 0; i < LANES; i++)
      if (txLane == LW'(i)) txByteData = txHead[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.txFlush) txLane <= '0;
    else if (txPop)              txLane <= '0;
    else if (txStep)             txLane <= txLane + LW'(1);
  end

  // receive packer: insert byte at its lane, upper lanes stay zero
  assign rxByteReady = !rxFull && !strobe.rxFlush;

  always_comb begin
    rxWord = rxAccum;
    for (int i = 0; i < LANES; i++)
      if (rxLane == LW'(i)) rxWord[i*BYTE_W +: BYTE_W] = rxByteData;
  end

  assign rxPush = rxByteValid && rxByteReady &&
                  (rxByteLast || rxLane == LW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.rxFlush) begin
      rxLane  <= '0;
      rxAccum <= '0;
    end else if (rxByteValid && rxByteReady) begin
      if (rxPush) begin
        rxLane  <= '0;
        rxAccum <= '0;
      end else begin
        rxLane  <= rxLane + LW'(1);
        rxAccum <= rxWord;
      end
    end
  end

  assert_lane_reset_after_pop_R3: assert property (@(posedge clk) disable iff (!rstN)
    txPop |=> (txLane == '0));
endmodule

// File: rtl/queueControl.sv
module queueControl
  import i2cWordQueuePkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TRIG_W = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned FIELD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [1:0]        regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              txOverflow,
  output logic              rxUnderflow,
  output logic              txReq,
  output logic              rxReq,
  output queueStrobes_t     strobe,
  input  logic [WORD_W-1:0] rxHead,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic              txFull,
  input  logic              rxEmpty
);
  logic [TRIG_W-1:0] txTrig, rxTrig;
  logic flushTx, flushRx;
  logic ctrlWrite, txWrite, rxRead;
  logic [CW-1:0] txFree;

  assign ctrlWrite = regWrite && regAddr == ADDR_CTRL;
  assign txWrite   = regWrite && regAddr == ADDR_TXDATA;
  assign rxRead    = regRead  && regAddr == ADDR_RXDATA;
  assign txFree    = CW'(DEPTH) - txCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txTrig  <= '0;
      rxTrig  <= '0;
      flushTx <= 1'b0;
      flushRx <= 1'b0;
    end else if (ctrlWrite) begin
      txTrig  <= regWdata[7:5];
      rxTrig  <= regWdata[4:2];
      flushTx <= regWdata[1];
      flushRx <= regWdata[0];
    end else begin
      flushTx <= 1'b0;
      flushRx <= 1'b0;
    end
  end

  always_comb begin
    strobe.txFlush = flushTx;
    strobe.rxFlush = flushRx;
    strobe.txPush  = txWrite && !txFull && !flushTx;
    strobe.rxPop   = rxRead && !rxEmpty && !flushRx;
  end

  assign txOverflow  = txWrite && txFull;
  assign rxUnderflow = rxRead && rxEmpty;
  assign txReq = txFree  > CW'(txTrig);
  assign rxReq = rxCount > CW'(rxTrig);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_RXDATA: regRdata = rxEmpty ? '0 : rxHead;
      ADDR_CTRL:   regRdata[7:0] = {txTrig, rxTrig, flushTx, flushRx};
      ADDR_STATUS: regRdata[7:0] = {FIELD_W'(txFree), FIELD_W'(rxCount)};
      default:     regRdata = '0;
    endcase
  end

  assert_flush_selfclear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flushTx && !ctrlWrite) |=> !flushTx);
  assert_underflow_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderflow |-> (regRdata == '0));
endmodule

// File: rtl/i2cWordQueue.sv
module i2cWordQueue
  import i2cWordQueuePkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TRIG_W = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrite,
  input  logic        regRead,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        txOverflow,
  output logic        rxUnderflow,
  output logic        txReq,
  output logic        rxReq,
  output logic        txByteValid,
  output logic [7:0]  txByteData,
  input  logic        txByteTake,
  input  logic        txByteLast,
  input  logic        rxByteValid,
  input  logic [7:0]  rxByteData,
  input  logic        rxByteLast,
  output logic        rxByteReady
);
  queueStrobes_t strobe;
  logic [WORD_W-1:0] rxHead;
  logic [CW-1:0] txCount, rxCount;
  logic txFull, rxEmpty;

  queueControl #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txOverflow(txOverflow), .rxUnderflow(rxUnderflow),
    .txReq(txReq), .rxReq(rxReq), .strobe(strobe), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .rxEmpty(rxEmpty));

  queueDatapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(regWdata),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .rxEmpty(rxEmpty),
    .txByteValid(txByteValid), .txByteData(txByteData),
    .txByteTake(txByteTake), .txByteLast(txByteLast),
    .rxByteValid(rxByteValid), .rxByteData(rxByteData),
    .rxByteLast(rxByteLast), .rxByteReady(rxByteReady));
endmodule

// File: tb/tb_i2cWordQueue.sv
module tb_i2cWordQueue;
  logic clk = 0, rstN = 0;
  logic regWrite = 0, regRead = 0;
  logic [1:0] regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic txOverflow, rxUnderflow, txReq, rxReq, txByteValid, rxByteReady;
  logic [7:0] txByteData;
  logic txByteTake = 0, txByteLast = 0, rxByteValid = 0, rxByteLast = 0;
  logic [7:0] rxByteData = 0;

  int total = 0, bad = 0;
  logic [7:0]  txExp[$];
  logic        txExpLast[$];
  logic [31:0] rxExp[$];

  always #2 clk = ~clk;

  i2cWordQueue dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrite = 0;
  endtask

  task automatic hostPeek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic hostPop(output logic [31:0] d, output logic uf);
    @(negedge clk); regRead = 1; regAddr = 2'd1; #1 d = regRdata; uf = rxUnderflow;
    @(negedge clk); regRead = 0;
  endtask

  // driver: push a word and record the bytes the engine will take
  task automatic pushTx(input logic [31:0] w, input int nBytes);
    hostWrite(2'd0, w);
    for (int i = 0; i < nBytes; i++) begin
      txExp.push_back(w[i*8 +: 8]);
      txExpLast.push_back(i == nBytes - 1 && nBytes < 4);
    end
  endtask

  // monitor: consume expected bytes, comparing the offered byte
  task automatic drainTx(input string req);
    while (txExp.size() > 0) begin
      logic [7:0] e = txExp.pop_front();
      logic l = txExpLast.pop_front();
      @(negedge clk); #1;
      check(req, {txByteValid, txByteData}, {1'b1, e});
      txByteTake = 1; txByteLast = l;
      @(negedge clk); txByteTake = 0; txByteLast = 0;
    end
  endtask

  task automatic sendRx(input logic [31:0] w, input int nBytes);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      rxByteValid = 1; rxByteData = w[i*8 +: 8]; rxByteLast = (i == nBytes - 1);
      @(negedge clk); rxByteValid = 0; rxByteLast = 0;
    end
    rxExp.push_back(nBytes == 4 ? w : (w & ((32'h1 << (nBytes*8)) - 1)));
  endtask

  task automatic drainRx(input string req);
    logic [31:0] d; logic uf;
    while (rxExp.size() > 0) begin
      logic [31:0] e = rxExp.pop_front();
      hostPop(d, uf);
      check(req, d, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d; logic uf;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    hostPeek(2'd2, d); check("R1 ctrl", d, 32'h0);
    hostPeek(2'd3, d); check("R1 status", d, 32'h80);
    check("R1 flags", {txReq, rxReq, txByteValid}, 3'b100);

    // R2 / R10 full words, order kept
    pushTx(32'h44332211, 4);
    pushTx(32'h88776655, 4);
    hostPeek(2'd3, d); check("R5 free after two pushes", d, 32'h60);
    drainTx("R2 R10 tx byte order");

    // R3 partial words
    pushTx(32'hDDCCBBAA, 2);
    pushTx(32'h0F0E0D0C, 3);
    pushTx(32'h13121110, 4);
    drainTx("R3 partial tx");
    @(negedge clk); #1 check("R3 tx empty", txByteValid, 1'b0);

    // R4 / R10 rx packing
    sendRx(32'hA4A3A2A1, 4);
    sendRx(32'hFFFFB2B1, 2);
    sendRx(32'hFFC3C2C1, 3);
    hostPeek(2'd3, d); check("R5 rx filled", d, 32'h83);
    drainRx("R4 R10 rx packing");

    // R9 underflow
    hostPop(d, uf);
    check("R9 underflow data", d, 32'h0);
    check("R9 underflow flag", uf, 1'b1);

    // R8 overflow
    for (int i = 0; i < 8; i++) hostWrite(2'd0, 32'h100 + i);
    @(negedge clk); regWrite = 1; regAddr = 2'd0; regWdata = 32'hDEAD; #1;
    check("R8 overflow flag", txOverflow, 1'b1);
    @(negedge clk); regWrite = 0;
    hostPeek(2'd3, d); check("R8 free stays 0", d, 32'h00);
    check("R7 txReq at full", txReq, 1'b0);
    @(negedge clk); #1 check("R8 head intact", {txByteValid, txByteData}, 9'h100);

    // R6 flush tx, self clear
    sendRx(32'h0, 1);
    rxExp.delete();
    @(negedge clk); regWrite = 1; regAddr = 2'd2; regWdata = 32'h3;
    @(negedge clk); regWrite = 0; regAddr = 2'd2; #1;
    check("R6 flush bits visible", regRdata[1:0], 2'b11);
    @(negedge clk); #1 check("R6 flush bits cleared", regRdata[1:0], 2'b00);
    hostPeek(2'd3, d); check("R6 queues empty", d, 32'h80);

    // R6 partial rx state discarded by flush
    sendRx(32'h0000EE, 1);
    rxExp.delete();
    @(negedge clk); rxByteValid = 1; rxByteData = 8'hEE; rxByteLast = 0;
    @(negedge clk); rxByteValid = 0;
    hostWrite(2'd2, 32'h1);
    @(negedge clk);
    sendRx(32'h00000055, 1);
    drainRx("R6 rx packer cleared");

    // R7 triggers
    hostWrite(2'd2, {24'h0, 3'd5, 3'd1, 2'b00});
    hostPeek(2'd2, d); check("R7 trig readback", d, 32'hA4);
    pushTx(32'h1, 4); pushTx(32'h2, 4); pushTx(32'h3, 4);
    @(negedge clk); #1 check("R7 txReq free5 trig5", txReq, 1'b0);
    sendRx(32'h11, 4);
    @(negedge clk); #1 check("R7 rxReq filled1 trig1", rxReq, 1'b0);
    sendRx(32'h22, 4);
    @(negedge clk); #1 check("R7 rxReq filled2 trig1", rxReq, 1'b1);
    drainTx("R2 after triggers");
    @(negedge clk); #1 check("R7 txReq free8 trig5", txReq, 1'b1);
    drainRx("R4 after triggers");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule